// File: doc/BRIEF.md
# Timestamped Event Deferral Lock

This block gives user code a cheap, self-expiring lock against asynchronous events such as signals or reschedule requests. A lock request does not set a flag that must later be cleared. It writes a stamp derived from a free-running 32-bit timer. The lock counts as held only while the timer has advanced no further than a configurable window past that stamp. Software therefore never issues an explicit unlock. The lock lapses on its own once it ages out.

Events that arrive while the stamp is fresh are not delivered at once. They are remembered in a break flag. The held event is handed over in one of two ways. A periodic tick that finds the stamp stale clears the stamp and raises a one-cycle delivery strobe. A later lock attempt that finds the break flag set is refused and raises a one-cycle trap strobe, so a caller cannot hold events off indefinitely by re-locking. The timer value and the window are inputs, and the window is loaded by a configuration write.

Top module: `evt_defer_lock`

## Requirements
- R1: After reset both output strobes are low, no lock is held, and the window equals the parameter WINDOW_RST (default 16).
- R2: A lock request made while the break flag is clear is granted; an event whose timer value Te satisfies (Te - Tl) mod 2^32 <= window, where Tl is the timer value at the grant, is then held back.
- R3: A granted lock always yields a non-zero stamp: a grant at timer value all-ones stores stamp 1, and the age is then measured as (timer + 1 - 1), so that lock is held and not taken for "no lock".
- R4: An event that finds a fresh stamp produces no delivery strobe and sets the break flag.
- R5: An event that finds no lock, or a stale stamp, produces `evt_deliver` high in the cycle after the request.
- R6: A lock request made while the break flag is set is refused: `trap_req` pulses, the stamp is cleared, and the break flag is cleared, so a following event is delivered at once and a following lock is granted without a trap.
- R7: A tick that finds a non-zero stale stamp clears it; if the break flag is set, `evt_deliver` pulses and the flag is cleared, so a second tick gives no strobe.
- R8: A tick that finds a fresh stamp has no effect: the lock stays held and the break flag stays set.
- R9: When a lock request and an event come in the same cycle, the lock is handled first: with the flag clear the event is held; with the flag set the trap fires and the event is delivered in that same cycle.
- R10: A configuration write loads the window; an event at age equal to the window is held, and one at age window + 1 is delivered.
- R11: Age comparison wraps modulo 2^32, so a lock taken just before the timer wraps stays fresh across the wrap.
- R12: Both strobes are registered and last exactly one cycle per cause.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_req | input | 1 | Request to take the deferral lock |
| evt_req | input | 1 | Asynchronous event request (already synchronised) |
| tick | input | 1 | Periodic housekeeping pulse that ages out stamps |
| timer | input | 32 | Current free-running timer value |
| cfg_we | input | 1 | Load strobe for the freshness window |
| cfg_window | input | 32 | New freshness window value |
| evt_deliver | output | 1 | One-cycle strobe: an event is handed on |
| trap_req | output | 1 | One-cycle strobe: lock refused, held event must be taken |

## Verification
The assertions assume that `lock_req`, `evt_req` and `tick` are single-cycle pulses sampled on the clock and that the timer moves forward between calls. They also assume the window stays well below half the timer range, so that the wrapping age keeps its meaning. The stimulus drives each request for exactly one cycle with an explicit timer value, moves the timer only forward, and uses windows of 3 and 16. The wrap cases place the lock within a few counts of all-ones so that ages stay small across the boundary.

// File: rtl/edl_pkg.sv
package edl_pkg;

    localparam int EDL_TW = 32;

    typedef logic [EDL_TW-1:0] edl_word_t;

    typedef struct packed {
        edl_word_t stamp;
        logic      brk;
        logic      deliver;
        logic      trap;
    } edl_state_t;

endpackage

// File: rtl/edl_age_cmp.sv
module edl_age_cmp
    import edl_pkg::*;
(
    input  edl_word_t stamp_i,
    input  edl_word_t timer_i,
    input  edl_word_t window_i,
    output logic      held_o,
    output logic      stale_o
);

    edl_word_t age;
    logic      nonzero;

    always_comb begin
        // Wrapping distance from the stamp, counted so a fresh grant is age 0.
        age     = timer_i + edl_word_t'(1) - stamp_i;
        nonzero = (stamp_i != '0);
        held_o  = nonzero && (age <= window_i);
        stale_o = nonzero && (age > window_i);
    end

endmodule

// File: rtl/edl_stamp_gen.sv
module edl_stamp_gen
    import edl_pkg::*;
(
    input  edl_word_t timer_i,
    output edl_word_t stamp_o
);

    edl_word_t inc;

    always_comb begin
        inc = timer_i + edl_word_t'(1);
        // Zero is reserved for "unlocked"; the all-ones timer maps to 1.
        if (inc == '0) begin
            stamp_o = edl_word_t'(1);
        end else begin
            stamp_o = inc;
        end
    end

endmodule

// File: rtl/edl_window_reg.sv
module edl_window_reg
    import edl_pkg::*;
#(
    parameter edl_word_t WINDOW_RST = edl_word_t'(16)
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cfg_we,
    input  edl_word_t cfg_window,
    output edl_word_t window_o
);

    edl_word_t window_d, window_q;

    always_comb begin
        window_d = window_q;
        if (cfg_we) begin
            window_d = cfg_window;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            window_q <= WINDOW_RST;
        end else begin
            window_q <= window_d;
        end
    end

    assign window_o = window_q;

    assert_cfg_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cfg_we)) |-> (window_o == $past(cfg_window)))
        else $error("window not loaded");

    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(cfg_we)) |-> $stable(window_o))
        else $error("window changed without write");

endmodule

// File: rtl/evt_defer_lock.sv
module evt_defer_lock
    import edl_pkg::*;
#(
    parameter edl_word_t WINDOW_RST = edl_word_t'(16)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lock_req,
    input  logic        evt_req,
    input  logic        tick,
    input  logic [31:0] timer,
    input  logic        cfg_we,
    input  logic [31:0] cfg_window,
    output logic        evt_deliver,
    output logic        trap_req
);

    edl_state_t st_d, st_q;
    edl_word_t  window;
    edl_word_t  grant_stamp;
    edl_word_t  stamp_lk;
    logic       held_q, stale_q;
    logic       held_lk, stale_lk;
    logic       granted, refused;
    logic       brk_lk;

    edl_window_reg #(.WINDOW_RST(WINDOW_RST)) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_window (cfg_window),
        .window_o   (window)
    );

    edl_stamp_gen u_stamp (
        .timer_i (timer),
        .stamp_o (grant_stamp)
    );

    edl_age_cmp u_age (
        .stamp_i  (st_q.stamp),
        .timer_i  (timer),
        .window_i (window),
        .held_o   (held_q),
        .stale_o  (stale_q)
    );

    always_comb begin
        st_d         = st_q;
        st_d.deliver = 1'b0;
        st_d.trap    = 1'b0;

        // Stage 1: lock request takes precedence.
        granted  = lock_req && !st_q.brk;
        refused  = lock_req &&  st_q.brk;
        stamp_lk = st_q.stamp;
        brk_lk   = st_q.brk;
        held_lk  = held_q;
        stale_lk = stale_q;
        if (granted) begin
            stamp_lk = grant_stamp;
            held_lk  = 1'b1;
            stale_lk = 1'b0;
        end else if (refused) begin
            stamp_lk  = '0;
            brk_lk    = 1'b0;
            held_lk   = 1'b0;
            stale_lk  = 1'b0;
            st_d.trap = 1'b1;
        end
        st_d.stamp = stamp_lk;
        st_d.brk   = brk_lk;

        // Stage 2: event request sees the stamp after the lock stage.
        if (evt_req) begin
            if (held_lk) begin
                st_d.brk = 1'b1;
            end else begin
                st_d.deliver = 1'b1;
            end
        end

        // Stage 3: tick ages out a stale stamp and releases a held event.
        if (tick && stale_lk) begin
            st_d.stamp = '0;
            if (st_d.brk) begin
                st_d.brk     = 1'b0;
                st_d.deliver = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_deliver = st_q.deliver;
    assign trap_req    = st_q.trap;

    assert_trap_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && trap_req) |-> $past(lock_req))
        else $error("trap without lock request");

    assert_deliver_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && evt_deliver) |-> $past(evt_req || tick))
        else $error("delivery without event or tick");

    assert_grant_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(lock_req && !st_q.brk)) |-> (st_q.stamp != '0))
        else $error("granted lock left zero stamp");

    assert_brk_needs_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.brk |-> (st_q.stamp != '0))
        else $error("break flag set with no lock");

    assert_trap_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> !trap_req)
        else $error("trap strobe wider than one cycle");

    assert_tick_fresh_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(tick && !lock_req && !evt_req && held_q))
            |-> (st_q.stamp == $past(st_q.stamp) && st_q.brk == $past(st_q.brk)))
        else $error("tick disturbed a fresh lock");

endmodule

// File: tb/tb_evt_defer_lock.sv
`timescale 1ns/1ps
module tb_evt_defer_lock;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lock_req, evt_req, tick, cfg_we;
    logic [31:0] timer, cfg_window;
    logic        evt_deliver, trap_req;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    evt_defer_lock dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .lock_req    (lock_req),
        .evt_req     (evt_req),
        .tick        (tick),
        .timer       (timer),
        .cfg_we      (cfg_we),
        .cfg_window  (cfg_window),
        .evt_deliver (evt_deliver),
        .trap_req    (trap_req)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Drive one cycle of requests; on return the outputs reflect that cycle.
    task automatic step(input logic l, input logic e, input logic t, input logic [31:0] tv);
        lock_req = l; evt_req = e; tick = t; timer = tv;
        @(negedge clk);
        lock_req = 1'b0; evt_req = 1'b0; tick = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        lock_req = 1'b0; evt_req = 1'b0; tick = 1'b0; cfg_we = 1'b0;
        timer = '0; cfg_window = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic set_window(input logic [31:0] w);
        cfg_we = 1'b1; cfg_window = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic t_reset_default();
        do_reset();
        chk("R1", "deliver after reset", evt_deliver, 1'b0);
        chk("R1", "trap after reset", trap_req, 1'b0);
        step(0, 1, 0, 32'd5);
        chk("R5", "event with no lock", evt_deliver, 1'b1);
        step(0, 0, 0, 32'd6);
        chk("R12", "deliver pulse ends", evt_deliver, 1'b0);
        step(1, 0, 0, 32'd100);
        chk("R2", "grant raises no trap", trap_req, 1'b0);
        step(0, 1, 0, 32'd116);
        chk("R4", "event at default window edge held", evt_deliver, 1'b0);
        step(0, 1, 0, 32'd117);
        chk("R1", "event past default window delivered", evt_deliver, 1'b1);
        step(0, 0, 1, 32'd118);
        chk("R7", "stale tick releases held event", evt_deliver, 1'b1);
        step(0, 0, 1, 32'd119);
        chk("R7", "second tick gives nothing", evt_deliver, 1'b0);
    endtask

    task automatic t_trap();
        do_reset();
        step(1, 0, 0, 32'd10);
        step(0, 1, 0, 32'd12);
        chk("R4", "event under lock held", evt_deliver, 1'b0);
        step(1, 0, 0, 32'd13);
        chk("R6", "relock with break pending traps", trap_req, 1'b1);
        chk("R6", "no delivery with trap", evt_deliver, 1'b0);
        step(0, 0, 0, 32'd13);
        chk("R12", "trap pulse ends", trap_req, 1'b0);
        step(0, 1, 0, 32'd14);
        chk("R6", "refused lock left no lock", evt_deliver, 1'b1);
        step(1, 0, 0, 32'd15);
        chk("R6", "flag cleared by trap", trap_req, 1'b0);
    endtask

    task automatic t_tick_fresh();
        do_reset();
        step(1, 0, 0, 32'd50);
        step(0, 1, 0, 32'd52);
        step(0, 0, 1, 32'd55);
        chk("R8", "tick on fresh stamp silent", evt_deliver, 1'b0);
        step(0, 1, 0, 32'd56);
        chk("R8", "lock still held after tick", evt_deliver, 1'b0);
        step(0, 0, 1, 32'd100);
        chk("R7", "later stale tick releases", evt_deliver, 1'b1);
    endtask

    task automatic t_window();
        do_reset();
        set_window(32'd3);
        step(1, 0, 0, 32'd1000);
        step(0, 1, 0, 32'd1003);
        chk("R10", "event at age == window held", evt_deliver, 1'b0);
        step(0, 0, 1, 32'd1003);
        chk("R10", "tick at age == window silent", evt_deliver, 1'b0);
        step(0, 0, 1, 32'd1004);
        chk("R10", "tick at age window+1 releases", evt_deliver, 1'b1);
        step(1, 0, 0, 32'd2000);
        step(0, 1, 0, 32'd2004);
        chk("R10", "event at age window+1 delivered", evt_deliver, 1'b1);
    endtask

    task automatic t_wrap();
        do_reset();
        step(1, 0, 0, 32'hFFFF_FFF8);
        step(0, 1, 0, 32'h0000_0004);
        chk("R11", "lock fresh across wrap", evt_deliver, 1'b0);
        step(0, 0, 1, 32'h0000_0009);
        chk("R11", "stale after wrap releases", evt_deliver, 1'b1);
    endtask

    task automatic t_all_ones();
        do_reset();
        step(1, 0, 0, 32'hFFFF_FFFF);
        step(0, 1, 0, 32'h0000_000F);
        chk("R3", "all-ones grant still held", evt_deliver, 1'b0);
        step(0, 0, 1, 32'h0000_0010);
        chk("R3", "age 16 from stamp 1 fresh", evt_deliver, 1'b0);
        step(0, 0, 1, 32'h0000_0011);
        chk("R3", "age 17 from stamp 1 stale", evt_deliver, 1'b1);
    endtask

    task automatic t_same_cycle();
        do_reset();
        step(1, 1, 0, 32'd300);
        chk("R9", "lock first then event held", evt_deliver, 1'b0);
        chk("R9", "no trap on first lock", trap_req, 1'b0);
        step(1, 1, 0, 32'd301);
        chk("R9", "trap with coincident event", trap_req, 1'b1);
        chk("R9", "coincident event delivered", evt_deliver, 1'b1);
        step(1, 0, 0, 32'd302);
        chk("R9", "lock after trap granted", trap_req, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset_default();
        t_trap();
        t_tick_fresh();
        t_window();
        t_wrap();
        t_all_ones();
        t_same_cycle();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule